// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a packed 32-bit timing word into the quantum and bit timing a CAN node needs. A prescaler divides the core clock into time quanta. A segment sequencer walks every bit through a one-quantum sync segment, a first time segment (propagation plus phase 1) and a second time segment. It raises a sample strobe at the end of the first segment and a bit strobe at the end of the bit. The sampled bus level comes out as `rx_bit`. It is either the level at the sample point or, in triple mode, the majority of the last three quantum samples.

The sequencer follows the bus. It looks for a falling edge, which is the bus being recessive (1) at one quantum boundary and dominant (0) at the next. An edge of this kind resynchronises the bit, and the adjustment is capped by the jump width. While the frame logic reports the bus idle, a falling edge instead causes a hard synchronisation that restarts the bit. The timing word is captured only while `cfg_hold` (controller held in reset mode) is high. While held, the block produces no quanta and restarts its timing.

Top module: `can_bit_timer`

## Requirements
- R1: Timing word fields: bits 9:0 hold prescaler minus one, bits 15:14 jump width minus one (1..4), bits 19:16 first segment minus one (1..16), bits 22:20 second segment minus one (1..8), bit 23 set selects triple sampling. `tq_tick` pulses once every prescaler clock cycles.
- R2: Without edges a bit lasts 1 + TS1 + TS2 quanta, and `bit_stb` pulses together with the `tq_tick` that ends its last quantum.
- R3: `sample_stb` pulses with the tick ending quantum TS1 of the bit (sync is quantum 0). It never pulses together with `bit_stb`.
- R4: `cfg_word` is captured only while `cfg_hold` is high. While `cfg_hold` is high no `tq_tick` pulses and the bit restarts at the sync segment. Changes to `cfg_word` while `cfg_hold` is low have no effect.
- R5: A falling edge in TS1 quantum k (1-based) lengthens TS1 by min(k, SJW) quanta.
- R6: A falling edge in TS2 with e quanta left in the segment (counting the edge quantum) does one of two things. If e <= SJW, it ends the bit at that quantum and the next bit starts directly in TS1. Otherwise it shortens TS2 by SJW quanta.
- R7: Falling edges in the sync quantum are ignored, and at most one resynchronisation takes effect per bit.
- R8: With `bus_idle` high, a falling edge in any quantum makes that quantum the sync quantum of a new bit. No strobe pulses at that tick.
- R9: In single mode `rx_bit` takes the bus level of the quantum that ends at the sample point. It changes only on a sample strobe.
- R10: In triple mode `rx_bit` takes the majority of the levels in the sample quantum and the two quanta before it.
- R11: After reset `tq_tick`, `sample_stb` and `bit_stb` are 0 and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hold | input | 1 | Controller in reset mode: capture timing word, stop timing |
| cfg_word | input | 32 | Packed timing word |
| rx_in | input | 1 | Bus level, 1 = recessive |
| bus_idle | input | 1 | Bus idle, enables hard synchronisation |
| tq_tick | output | 1 | One-cycle pulse per time quantum |
| sample_stb | output | 1 | Pulse at the sample point |
| bit_stb | output | 1 | Pulse at the end of each bit |
| rx_bit | output | 1 | Sampled bit value |

## Verification
The bench places falling edges in chosen quanta and measures strobe positions in quanta and the bit period in clock cycles. It covers an edge on the last TS1 quantum, where an off-by-one design would sample early rather than extend. It covers a TS2 edge within the jump width, where a wrong design would insert a spurious sync quantum or end the bit late. It covers a TS2 edge beyond it, where a wrong design would shorten by the full phase error. Other cases are a second edge in a bit that must be ignored, and a hard sync that must suppress the pending strobe. A one-quantum recessive glitch at the sample point over a dominant bit separates majority voting from single sampling. A timing word changed outside reset mode must leave the period untouched.

// File: rtl/cbt_pkg.sv
// Shared widths, field positions and types of the CAN bit timing generator.
// Assumes the 32-bit timing word layout described in the brief.
package cbt_pkg;
    localparam int BRP_W      = 10;
    localparam int SJW_W      = 2;
    localparam int TS1_W      = 4;
    localparam int TS2_W      = 3;
    localparam int BRP_LSB    = 0;
    localparam int SJW_LSB    = 14;
    localparam int TS1_LSB    = 16;
    localparam int TS2_LSB    = 20;
    localparam int TRIPLE_BIT = 23;
    localparam int CNT_W      = TS1_W + 2;

    typedef struct packed {
        logic [BRP_W-1:0] brp_m1;
        logic [SJW_W-1:0] sjw_m1;
        logic [TS1_W-1:0] ts1_m1;
        logic [TS2_W-1:0] ts2_m1;
        logic             triple;
    } cbt_cfg_t;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_TS1  = 2'd1,
        SEG_TS2  = 2'd2
    } cbt_seg_e;

    function automatic cbt_cfg_t cbt_unpack(input logic [31:0] w);
        cbt_cfg_t c;
        c.brp_m1 = w[BRP_LSB +: BRP_W];
        c.sjw_m1 = w[SJW_LSB +: SJW_W];
        c.ts1_m1 = w[TS1_LSB +: TS1_W];
        c.ts2_m1 = w[TS2_LSB +: TS2_W];
        c.triple = w[TRIPLE_BIT];
        return c;
    endfunction
endpackage

// File: rtl/cbt_prescaler.sv
// Time-quantum prescaler: tick is high for one cycle every brp_m1+1 cycles.
// Assumes brp_m1 is constant while hold is low; hold clears the count.
module cbt_prescaler #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] brp_m1,
    output logic         tick
);
    logic [W-1:0] pc_q;

    assign tick = !hold && (pc_q == brp_m1);

    // count clock cycles within one quantum
    always_ff @(posedge clk) begin
        if (!rst_n || hold) pc_q <= '0;
        else if (tick)      pc_q <= '0;
        else                pc_q <= pc_q + W'(1);
    end

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> pc_q <= brp_m1);
endmodule

// File: rtl/cbt_seg_ctl.sv
// Bit segment sequencer: sync, TS1, TS2 with resynchronisation and hard sync.
// Works on quantum granularity: the bus level is compared at consecutive ticks.
// Assumes the configuration is constant while hold is low.
module cbt_seg_ctl
    import cbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hold,
    input  logic     tick,
    input  logic     rx_in,
    input  logic     bus_idle,
    input  cbt_cfg_t cfg,
    output logic     sample_now,
    output logic     bit_now
);
    cbt_seg_e         seg_q, seg_n;
    logic [CNT_W-1:0] cnt_q, cnt_n, ext_q, ext_n, ext_v, phase;
    logic             shrunk_q, shrunk_n, shr_v, resync_q, resync_n, lvl_q;
    logic             early_end, samp_c, bit_c;
    logic [CNT_W-1:0] t1_nom, t2_nom, sjw, t2_end;
    logic             fall, hard;

    assign t1_nom = CNT_W'(cfg.ts1_m1) + CNT_W'(1);
    assign t2_nom = CNT_W'(cfg.ts2_m1) + CNT_W'(1);
    assign sjw    = CNT_W'(cfg.sjw_m1) + CNT_W'(1);
    assign fall   = lvl_q && !rx_in;
    assign hard   = bus_idle && fall;

    // next segment state for the quantum that ends at this tick
    always_comb begin
        seg_n = seg_q;  cnt_n = cnt_q;  ext_n = ext_q;
        shrunk_n = shrunk_q;  resync_n = resync_q;
        samp_c = 1'b0;  bit_c = 1'b0;  early_end = 1'b0;
        ext_v = ext_q;  shr_v = shrunk_q;  phase = '0;
        t2_end = t2_nom;
        if (hard) begin
            seg_n = SEG_TS1;  cnt_n = '0;  ext_n = '0;
            shrunk_n = 1'b0;  resync_n = 1'b0;
        end else begin
            case (seg_q)
                SEG_SYNC: begin
                    seg_n = SEG_TS1;
                    cnt_n = '0;
                end
                SEG_TS1: begin
                    if (fall && !resync_q) begin
                        phase    = cnt_q + CNT_W'(1);
                        ext_v    = (phase < sjw) ? phase : sjw;
                        resync_n = 1'b1;
                    end
                    ext_n = ext_v;
                    if (cnt_q == t1_nom + ext_v - CNT_W'(1)) begin
                        samp_c = 1'b1;
                        seg_n  = SEG_TS2;
                        cnt_n  = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_W'(1);
                    end
                end
                SEG_TS2: begin
                    if (fall && !resync_q) begin
                        phase    = t2_nom - cnt_q;
                        resync_n = 1'b1;
                        if (phase <= sjw) early_end = 1'b1;
                        else              shr_v = 1'b1;
                    end
                    t2_end = shr_v ? (t2_nom - sjw) : t2_nom;
                    if (early_end || cnt_q == t2_end - CNT_W'(1)) begin
                        bit_c    = 1'b1;
                        seg_n    = early_end ? SEG_TS1 : SEG_SYNC;
                        cnt_n    = '0;
                        ext_n    = '0;
                        shrunk_n = 1'b0;
                        resync_n = 1'b0;
                    end else begin
                        cnt_n    = cnt_q + CNT_W'(1);
                        shrunk_n = shr_v;
                    end
                end
                default: begin
                    seg_n = SEG_SYNC;
                    cnt_n = '0;
                end
            endcase
        end
    end

    assign sample_now = tick && samp_c;
    assign bit_now    = tick && bit_c;

    // advance the segment state once per quantum
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            seg_q <= SEG_SYNC;  cnt_q <= '0;  ext_q <= '0;
            shrunk_q <= 1'b0;  resync_q <= 1'b0;  lvl_q <= 1'b1;
        end else if (tick) begin
            seg_q <= seg_n;  cnt_q <= cnt_n;  ext_q <= ext_n;
            shrunk_q <= shrunk_n;  resync_q <= resync_n;  lvl_q <= rx_in;
        end
    end

    p_ts1_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seg_q == SEG_TS1 |-> cnt_q < t1_nom + ext_q);
    p_ext_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q <= sjw);
    p_ts2_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        seg_q == SEG_TS2 |-> cnt_q < (shrunk_q ? t2_nom - sjw : t2_nom));
    p_single_resync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seg_q == SEG_SYNC |-> !resync_q && ext_q == '0);
endmodule

// File: rtl/cbt_sampler.sv
// Bit sampler: single sampling or majority of three quantum samples.
// Assumes take is only high together with tick.
module cbt_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick,
    input  logic take,
    input  logic rx_in,
    input  logic triple,
    output logic rx_bit
);
    logic [1:0] hist_q;
    logic       vote;

    assign vote = (hist_q[1] & hist_q[0]) | (hist_q[1] & rx_in) | (hist_q[0] & rx_in);

    // keep the levels of the two previous quanta
    always_ff @(posedge clk) begin
        if (!rst_n || hold) hist_q <= 2'b11;
        else if (tick)      hist_q <= {hist_q[0], rx_in};
    end

    // capture the bit at the sample point
    always_ff @(posedge clk) begin
        if (!rst_n)             rx_bit <= 1'b1;
        else if (tick && take)  rx_bit <= triple ? vote : rx_in;
    end

    p_bit_only_at_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && take) |=> $stable(rx_bit));
endmodule

// File: rtl/can_bit_timer.sv
// CAN bit timing generator top: captures the timing word in reset mode,
// produces quantum, sample and bit strobes and the sampled bit.
// All outputs are registered; strobes appear one cycle after the internal tick.
module can_bit_timer
    import cbt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_hold,
    input  logic [31:0] cfg_word,
    input  logic        rx_in,
    input  logic        bus_idle,
    output logic        tq_tick,
    output logic        sample_stb,
    output logic        bit_stb,
    output logic        rx_bit
);
    cbt_cfg_t cfg_q;
    logic     tick, sample_now, bit_now;

    // capture the timing word only in reset mode
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '0;
        else if (cfg_hold) cfg_q <= cbt_unpack(cfg_word);
    end

    cbt_prescaler #(.W(BRP_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .hold(cfg_hold),
        .brp_m1(cfg_q.brp_m1), .tick(tick)
    );

    cbt_seg_ctl u_seg (
        .clk(clk), .rst_n(rst_n), .hold(cfg_hold), .tick(tick),
        .rx_in(rx_in), .bus_idle(bus_idle), .cfg(cfg_q),
        .sample_now(sample_now), .bit_now(bit_now)
    );

    cbt_sampler u_samp (
        .clk(clk), .rst_n(rst_n), .hold(cfg_hold), .tick(tick),
        .take(sample_now), .rx_in(rx_in), .triple(cfg_q.triple),
        .rx_bit(rx_bit)
    );

    // register the strobes so they leave the block glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tq_tick <= 1'b0;  sample_stb <= 1'b0;  bit_stb <= 1'b0;
        end else begin
            tq_tick    <= tick;
            sample_stb <= sample_now;
            bit_stb    <= bit_now;
        end
    end

    p_sample_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> tq_tick);
    p_bit_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> tq_tick);
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && bit_stb));
    p_no_tick_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hold |=> !tq_tick);
endmodule

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
    logic        clk = 1'b0, rst_n = 1'b0, cfg_hold = 1'b0, rx_in = 1'b1, bus_idle = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        tq_tick, sample_stb, bit_stb, rx_bit;
    int          errors = 0, checks = 0, cycles = 0;

    always #2.5 clk = ~clk;

    can_bit_timer u_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_word(cfg_word),
        .rx_in(rx_in), .bus_idle(bus_idle), .tq_tick(tq_tick),
        .sample_stb(sample_stb), .bit_stb(bit_stb), .rx_bit(rx_bit)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] pack(int b, int s, int t1, int t2, int tr);
        return 32'((b - 1) & 10'h3ff) | (32'((s - 1) & 3) << 14) |
               (32'((t1 - 1) & 15) << 16) | (32'((t2 - 1) & 7) << 20) | (32'(tr & 1) << 23);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    int c_b, c_s, c_t1, c_t2, c_tr;

    task automatic apply_cfg(input int b, input int s, input int t1, input int t2, input int tr);
        int seen;
        seen = 0;
        @(negedge clk);
        cfg_hold = 1'b1; cfg_word = pack(b, s, t1, t2, tr); rx_in = 1'b1; bus_idle = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (tq_tick) seen++;
        end
        chk("R4 ticks while held", seen, 0);
        cfg_hold = 1'b0;
        c_b = b; c_s = s; c_t1 = t1; c_t2 = t2; c_tr = tr;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (bit_stb) break;
        end
    endtask

    task automatic act(input int n, input int lo, input int hi, input int lo2);
        if (n == lo)  rx_in = 1'b0;
        if (n == hi)  rx_in = 1'b1;
        if (n == lo2) rx_in = 1'b0;
    endtask

    // counts ticks from the last bit strobe to the next one
    task automatic run_bit(input int lo, input int hi, input int lo2,
                           output int ns, output int nb, output int cyc, output int bv);
        int n;
        n = 0; ns = -1; nb = -1; cyc = 0; bv = -1;
        act(0, lo, hi, lo2);
        while (cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (tq_tick) begin
                n++;
                if (sample_stb) begin ns = n; bv = int'(rx_bit); end
                if (bit_stb) begin nb = n; break; end
                act(n, lo, hi, lo2);
            end
        end
    endtask

    // expected strobe ticks for one falling edge in quantum m
    task automatic exp_edge(input int m, output int ens, output int enb, output int chain);
        int e;
        chain = 0;
        if (m <= c_t1) begin
            ens = 1 + c_t1 + ((m < c_s) ? m : c_s);
            enb = ens + c_t2;
        end else begin
            e = c_t1 + c_t2 + 1 - m;
            ens = 1 + c_t1;
            if (e <= c_s) begin enb = m + 1; chain = 1; end
            else enb = 1 + c_t1 + c_t2 - c_s;
        end
    endtask

    int ns, nb, cyc, bv, ens, enb, chain, b, s, t1, t2, tr, m, seed;

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 tq_tick reset", int'(tq_tick), 0);
        chk("R11 sample_stb reset", int'(sample_stb), 0);
        chk("R11 bit_stb reset", int'(bit_stb), 0);
        chk("R11 rx_bit reset", int'(rx_bit), 1);
        rst_n = 1'b1;

        // directed: brp 2, sjw 2, ts1 4, ts2 6, single sampling
        apply_cfg(2, 2, 4, 6, 0);
        run_bit(-1, -1, -1, ns, nb, cyc, bv);
        chk("R3 sample tick", ns, 5);
        chk("R2 bit ticks", nb, 11);
        chk("R1 bit cycles", cyc, 22);
        chk("R9 recessive bit", bv, 1);
        rx_in = 1'b1;
        run_bit(2, -1, -1, ns, nb, cyc, bv);
        chk("R5 TS1 edge sample", ns, 7);
        chk("R5 TS1 edge bit", nb, 13);
        rx_in = 1'b1;
        run_bit(4, -1, -1, ns, nb, cyc, bv);
        chk("R5 last TS1 quantum edge sample", ns, 7);
        rx_in = 1'b1;
        run_bit(2, 3, 10, ns, nb, cyc, bv);
        chk("R7 second edge ignored sample", ns, 7);
        chk("R7 second edge ignored bit", nb, 13);
        rx_in = 1'b1;
        run_bit(0, -1, -1, ns, nb, cyc, bv);
        chk("R7 sync edge ignored sample", ns, 5);
        chk("R7 sync edge ignored bit", nb, 11);
        chk("R9 dominant bit", bv, 0);
        rx_in = 1'b1;
        run_bit(9, -1, -1, ns, nb, cyc, bv);
        chk("R6 early end bit", nb, 10);
        run_bit(-1, -1, -1, ns, nb, cyc, bv);
        chk("R6 next bit starts in TS1 sample", ns, 4);
        chk("R6 next bit starts in TS1 bit", nb, 10);
        rx_in = 1'b1;
        run_bit(6, -1, -1, ns, nb, cyc, bv);
        chk("R6 shortened bit", nb, 9);
        rx_in = 1'b1;
        run_bit(0, 4, 5, ns, nb, cyc, bv);
        chk("R9 single sample of glitch", bv, 1);
        chk("R6 glitch run bit", nb, 9);
        rx_in = 1'b1;
        bus_idle = 1'b1;
        run_bit(8, -1, -1, ns, nb, cyc, bv);
        chk("R8 hard sync sample", ns, 13);
        chk("R8 hard sync bit", nb, 19);
        bus_idle = 1'b0; rx_in = 1'b1;
        cfg_word = pack(5, 1, 2, 2, 1);
        run_bit(-1, -1, -1, ns, nb, cyc, bv);
        chk("R4 word ignored outside hold ticks", nb, 11);
        chk("R4 word ignored outside hold cycles", cyc, 22);

        // directed: triple sampling
        apply_cfg(3, 1, 5, 3, 1);
        run_bit(-1, -1, -1, ns, nb, cyc, bv);
        chk("R2 triple cfg bit ticks", nb, 9);
        chk("R1 triple cfg cycles", cyc, 27);
        run_bit(0, 5, 6, ns, nb, cyc, bv);
        chk("R10 majority rejects glitch", bv, 0);
        chk("R6 triple glitch bit", nb, 8);
        rx_in = 1'b1;
        run_bit(-1, -1, -1, ns, nb, cyc, bv);
        chk("R10 majority recessive", bv, 1);

        // constrained random configurations and edge positions
        seed = $urandom(32'h5eed1);
        for (int it = 0; it < 24; it++) begin
            b = 1 + int'($urandom % 6); s = 1 + int'($urandom % 4);
            t1 = 1 + int'($urandom % 16); t2 = 1 + int'($urandom % 8);
            tr = int'($urandom % 2);
            apply_cfg(b, s, t1, t2, tr);
            run_bit(-1, -1, -1, ns, nb, cyc, bv);
            chk("R3 random sample", ns, 1 + t1);
            chk("R2 random bit", nb, 1 + t1 + t2);
            chk("R1 random cycles", cyc, b * (1 + t1 + t2));
            m = 1 + int'($urandom % (t1 + t2));
            rx_in = 1'b1;
            run_bit(m, -1, -1, ns, nb, cyc, bv);
            exp_edge(m, ens, enb, chain);
            chk("R5 random edge sample", ns, ens);
            chk("R6 random edge bit", nb, enb);
            if (chain != 0) begin
                run_bit(-1, -1, -1, ns, nb, cyc, bv);
                chk("R6 random chained bit", nb, t1 + t2);
            end
            rx_in = 1'b1;
            if (t1 >= 2) begin
                run_bit(0, t1, t1 + 1, ns, nb, cyc, bv);
                chk("R10 random glitch vote", bv, (tr != 0) ? 0 : 1);
                exp_edge(t1 + 1, ens, enb, chain);
                chk("R6 random glitch bit", nb, enb);
                if (chain != 0) run_bit(-1, -1, -1, ns, nb, cyc, bv);
                rx_in = 1'b1;
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule